// File: doc/BRIEF.md
# Single-Cycle Processor Control Decoder

This block is the control unit of a 32-bit single-cycle processor core with a classic three-format instruction word. It looks at the 6-bit major opcode (instruction bits 31:26) and the 6-bit function field (bits 5:0), together with the zero flag of the ALU. From these it produces every select and enable the datapath needs to finish one instruction in one clock. These are the next-PC source, the register-file write address and write data sources, both ALU operand sources, the immediate extension mode, a structured 5-bit ALU function code, the register-file write enable and the memory write enable.

The decoder is purely combinational. The datapath wires the outputs straight to its multiplexers, and branch resolution uses the zero flag computed in the same cycle. An opcode or function value outside the supported set is reported on a dedicated flag, and in that case no state is allowed to change.

Top module: `ctl_decoder`

## Requirements
- R1: With opcode 000000, the function codes 100000/100001 give ALU code 00001 and 100010/100011 give 10001. 100100, 100101, 100110 and 100111 give 00000, 00100, 01000 and 01100. The ALU code bits are {subtract, bool[1:0], shift, math}. Every one of these sets wa_sel=0 (rd), wd_sel=1 (ALU result), a_sel=0 (rs), b_sel=0 (rt), pc_sel=0 and rf_we=1.
- R2: Shifts with opcode 000000 have these codes: funct 000000/000100 give ALU 00010 (left), 000010/000110 give 01010 (logical right) and 000011/000111 give 01110 (arithmetic right). Funct values with bit 2 clear take the amount from shamt (a_sel=1). Funct values with bit 2 set take it from rs (a_sel=0). All shifts write rd with the ALU result.
- R3: Set-less-than uses ALU 10011 for the signed form and 10111 for the unsigned form. This holds for funct 101010/101011 (result written to rd) and for opcodes 001010/001011 (immediate sign-extended, result written to rt).
- R4: Immediate ALU opcodes 001000/001001 (add, code 00001), 001100 (and, 00000), 001101 (or, 00100) and 001110 (xor, 01000) all select b_sel=1 (immediate), wa_sel=1 (rt), wd_sel=1 and rf_we=1. sign_ext is 1 for the add forms and 0 for the logic forms.
- R5: Opcode 001111 (load upper) selects a_sel=2 (constant 16), b_sel=1, sign_ext=0, ALU 00010, wa_sel=1 and rf_we=1.
- R6: Opcode 100011 (load word) gives ALU 00001, b_sel=1, sign_ext=1, wd_sel=2 (memory data), wa_sel=1 and rf_we=1. Opcode 101011 (store word) gives ALU 00001, b_sel=1, sign_ext=1, mem_we=1 and rf_we=0.
- R7: Opcodes 000100 (branch if equal) and 000101 (branch if not equal) give ALU 10001, b_sel=0, sign_ext=1 and rf_we=0. pc_sel is 1 (branch target) when zero=1 for 000100 or zero=0 for 000101, and 0 (PC+4) otherwise.
- R8: Opcodes 000010 and 000011 give pc_sel=2 (jump target). 000011 also writes PC+4 (wd_sel=0) to register 31 (wa_sel=2) with rf_we=1. 000010 keeps rf_we=0.
- R9: Opcode 000000 with funct 001000 or 001001 gives pc_sel=3 (register target). Funct 001001 also writes PC+4 (wd_sel=0) to rd (wa_sel=0). Funct 001000 keeps rf_we=0.
- R10: mem_we is 1 only for opcode 101011.
- R11: Any other opcode, and any other funct under opcode 000000, sets bad_op=1 with rf_we=0, mem_we=0 and pc_sel=0.
- R12: The zero flag changes no output except pc_sel of the two branch opcodes. The function field has no effect when the opcode is not 000000. Every select that a given instruction does not use is driven to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 6 | Major opcode, instruction bits 31:26 |
| funct | input | 6 | Function field, instruction bits 5:0 |
| zero | input | 1 | ALU result-is-zero flag for the current instruction |
| pc_sel | output | 2 | Next PC: 0 PC+4, 1 branch target, 2 jump target, 3 register target |
| wa_sel | output | 2 | Write address: 0 rd, 1 rt, 2 register 31 |
| wd_sel | output | 2 | Write data: 0 PC+4, 1 ALU result, 2 memory read data |
| a_sel | output | 2 | ALU A: 0 rs value, 1 shamt field, 2 constant 16 |
| b_sel | output | 1 | ALU B: 0 rt value, 1 extended immediate |
| sign_ext | output | 1 | Immediate extension: 1 sign, 0 zero |
| alu_fn | output | 5 | ALU code {subtract, bool[1:0], shift, math} |
| rf_we | output | 1 | Register-file write enable |
| mem_we | output | 1 | Data memory write enable |
| bad_op | output | 1 | Unsupported opcode or function code |

## Verification
Every output is due in the same cycle as its inputs, because there is no register between the instruction fields, the zero flag and the control outputs. The bench drives op, funct and zero on the rising edge of its pacing clock and samples all outputs on the falling edge. Each vector therefore gets half a period to settle and is read before the next stimulus. For branches, the zero flag is toggled on its own while the opcode stays fixed, so the change in pc_sel can be tied to that input alone.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    parameter int OP_W    = 6;
    parameter int FN_W    = 6;
    parameter int ALUFN_W = 5;
    parameter int SEL_W   = 2;

    // major opcodes
    localparam logic [OP_W-1:0] OPC_REG      = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JMP      = 6'b000010;
    localparam logic [OP_W-1:0] OPC_JMP_LINK = 6'b000011;
    localparam logic [OP_W-1:0] OPC_BR_EQ    = 6'b000100;
    localparam logic [OP_W-1:0] OPC_BR_NE    = 6'b000101;
    localparam logic [OP_W-1:0] OPC_ADD_I    = 6'b001000;
    localparam logic [OP_W-1:0] OPC_ADDU_I   = 6'b001001;
    localparam logic [OP_W-1:0] OPC_LT_I     = 6'b001010;
    localparam logic [OP_W-1:0] OPC_LTU_I    = 6'b001011;
    localparam logic [OP_W-1:0] OPC_AND_I    = 6'b001100;
    localparam logic [OP_W-1:0] OPC_OR_I     = 6'b001101;
    localparam logic [OP_W-1:0] OPC_XOR_I    = 6'b001110;
    localparam logic [OP_W-1:0] OPC_UPPER    = 6'b001111;
    localparam logic [OP_W-1:0] OPC_LOAD     = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE    = 6'b101011;

    // function codes under OPC_REG
    localparam logic [FN_W-1:0] FN_SHL_C  = 6'b000000;
    localparam logic [FN_W-1:0] FN_SHR_C  = 6'b000010;
    localparam logic [FN_W-1:0] FN_SHA_C  = 6'b000011;
    localparam logic [FN_W-1:0] FN_SHL_V  = 6'b000100;
    localparam logic [FN_W-1:0] FN_SHR_V  = 6'b000110;
    localparam logic [FN_W-1:0] FN_SHA_V  = 6'b000111;
    localparam logic [FN_W-1:0] FN_JREG   = 6'b001000;
    localparam logic [FN_W-1:0] FN_JREG_L = 6'b001001;
    localparam logic [FN_W-1:0] FN_ADD    = 6'b100000;
    localparam logic [FN_W-1:0] FN_ADDU   = 6'b100001;
    localparam logic [FN_W-1:0] FN_SUB    = 6'b100010;
    localparam logic [FN_W-1:0] FN_SUBU   = 6'b100011;
    localparam logic [FN_W-1:0] FN_AND    = 6'b100100;
    localparam logic [FN_W-1:0] FN_OR     = 6'b100101;
    localparam logic [FN_W-1:0] FN_XOR    = 6'b100110;
    localparam logic [FN_W-1:0] FN_NOR    = 6'b100111;
    localparam logic [FN_W-1:0] FN_LT     = 6'b101010;
    localparam logic [FN_W-1:0] FN_LTU    = 6'b101011;

    // select encodings
    localparam logic [SEL_W-1:0] PC_SEQ  = 2'd0;
    localparam logic [SEL_W-1:0] PC_BR   = 2'd1;
    localparam logic [SEL_W-1:0] PC_JMP  = 2'd2;
    localparam logic [SEL_W-1:0] PC_REG  = 2'd3;
    localparam logic [SEL_W-1:0] WA_RD   = 2'd0;
    localparam logic [SEL_W-1:0] WA_RT   = 2'd1;
    localparam logic [SEL_W-1:0] WA_LINK = 2'd2;
    localparam logic [SEL_W-1:0] WD_LINK = 2'd0;
    localparam logic [SEL_W-1:0] WD_ALU  = 2'd1;
    localparam logic [SEL_W-1:0] WD_MEM  = 2'd2;
    localparam logic [SEL_W-1:0] AS_REG  = 2'd0;
    localparam logic [SEL_W-1:0] AS_SHAMT = 2'd1;
    localparam logic [SEL_W-1:0] AS_K16  = 2'd2;

    // instruction classes
    typedef enum logic [3:0] {
        K_BAD,
        K_ALU_R,
        K_SHIFT_C,
        K_SHIFT_V,
        K_JREG,
        K_JREG_L,
        K_ALU_I,
        K_UPPER,
        K_LOAD,
        K_STORE,
        K_BR_EQ,
        K_BR_NE,
        K_JMP,
        K_JMP_L
    } kind_e;

    // abstract ALU operations, mapped to the structured code later
    typedef enum logic [3:0] {
        AO_ADD, AO_SUB, AO_LT, AO_LTU,
        AO_SHL, AO_SHR, AO_SHA,
        AO_AND, AO_OR, AO_XOR, AO_NOR,
        AO_NONE
    } aluop_e;

    typedef struct packed {
        logic [SEL_W-1:0]   pc_sel;
        logic [SEL_W-1:0]   wa_sel;
        logic [SEL_W-1:0]   wd_sel;
        logic [SEL_W-1:0]   a_sel;
        logic               b_sel;
        logic               sign_ext;
        logic [ALUFN_W-1:0] alu_fn;
        logic               rf_we;
        logic               mem_we;
        logic               bad_op;
    } ctl_t;

endpackage

// File: rtl/ctl_classify.sv
module ctl_classify
    import ctl_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic [FN_W-1:0] funct,
    output kind_e           kind,
    output aluop_e          aluop,
    output logic            sext
);

    kind_e  kind_d;
    aluop_e aluop_d;
    logic   sext_d;

    always_comb begin
        kind_d  = K_BAD;
        aluop_d = AO_NONE;
        sext_d  = 1'b0;
        unique case (op)
            OPC_REG: begin
                unique case (funct)
                    FN_ADD, FN_ADDU: begin kind_d = K_ALU_R;   aluop_d = AO_ADD; end
                    FN_SUB, FN_SUBU: begin kind_d = K_ALU_R;   aluop_d = AO_SUB; end
                    FN_AND:          begin kind_d = K_ALU_R;   aluop_d = AO_AND; end
                    FN_OR:           begin kind_d = K_ALU_R;   aluop_d = AO_OR;  end
                    FN_XOR:          begin kind_d = K_ALU_R;   aluop_d = AO_XOR; end
                    FN_NOR:          begin kind_d = K_ALU_R;   aluop_d = AO_NOR; end
                    FN_LT:           begin kind_d = K_ALU_R;   aluop_d = AO_LT;  end
                    FN_LTU:          begin kind_d = K_ALU_R;   aluop_d = AO_LTU; end
                    FN_SHL_C:        begin kind_d = K_SHIFT_C; aluop_d = AO_SHL; end
                    FN_SHR_C:        begin kind_d = K_SHIFT_C; aluop_d = AO_SHR; end
                    FN_SHA_C:        begin kind_d = K_SHIFT_C; aluop_d = AO_SHA; end
                    FN_SHL_V:        begin kind_d = K_SHIFT_V; aluop_d = AO_SHL; end
                    FN_SHR_V:        begin kind_d = K_SHIFT_V; aluop_d = AO_SHR; end
                    FN_SHA_V:        begin kind_d = K_SHIFT_V; aluop_d = AO_SHA; end
                    FN_JREG:         kind_d = K_JREG;
                    FN_JREG_L:       kind_d = K_JREG_L;
                    default:         kind_d = K_BAD;
                endcase
            end
            OPC_ADD_I, OPC_ADDU_I: begin kind_d = K_ALU_I; aluop_d = AO_ADD; sext_d = 1'b1; end
            OPC_LT_I:   begin kind_d = K_ALU_I; aluop_d = AO_LT;  sext_d = 1'b1; end
            OPC_LTU_I:  begin kind_d = K_ALU_I; aluop_d = AO_LTU; sext_d = 1'b1; end
            OPC_AND_I:  begin kind_d = K_ALU_I; aluop_d = AO_AND; end
            OPC_OR_I:   begin kind_d = K_ALU_I; aluop_d = AO_OR;  end
            OPC_XOR_I:  begin kind_d = K_ALU_I; aluop_d = AO_XOR; end
            OPC_UPPER:  begin kind_d = K_UPPER; aluop_d = AO_SHL; end
            OPC_LOAD:   begin kind_d = K_LOAD;  aluop_d = AO_ADD; sext_d = 1'b1; end
            OPC_STORE:  begin kind_d = K_STORE; aluop_d = AO_ADD; sext_d = 1'b1; end
            OPC_BR_EQ:  begin kind_d = K_BR_EQ; aluop_d = AO_SUB; sext_d = 1'b1; end
            OPC_BR_NE:  begin kind_d = K_BR_NE; aluop_d = AO_SUB; sext_d = 1'b1; end
            OPC_JMP:    kind_d = K_JMP;
            OPC_JMP_LINK: kind_d = K_JMP_L;
            default:    kind_d = K_BAD;
        endcase
    end

    assign kind  = kind_d;
    assign aluop = aluop_d;
    assign sext  = sext_d;

endmodule

// File: rtl/ctl_alu_enc.sv
module ctl_alu_enc
    import ctl_pkg::*;
(
    input  aluop_e             aluop,
    output logic [ALUFN_W-1:0] alu_fn
);

    // code layout {subtract, bool[1:0], shift, math}
    localparam int B_MATH = 0;
    localparam int B_SHFT = 1;
    localparam int B_BOOL = 2;
    localparam int B_SUB  = ALUFN_W - 1;

    logic       sub_d;
    logic [1:0] bool_d;
    logic       shft_d;
    logic       math_d;
    logic [ALUFN_W-1:0] fn_d;

    always_comb begin
        sub_d  = 1'b0;
        bool_d = 2'b00;
        shft_d = 1'b0;
        math_d = 1'b0;
        unique case (aluop)
            AO_ADD: math_d = 1'b1;
            AO_SUB: begin sub_d = 1'b1; math_d = 1'b1; end
            AO_LT:  begin sub_d = 1'b1; shft_d = 1'b1; math_d = 1'b1; end
            AO_LTU: begin sub_d = 1'b1; bool_d = 2'b01; shft_d = 1'b1; math_d = 1'b1; end
            AO_SHL: shft_d = 1'b1;
            AO_SHR: begin bool_d = 2'b10; shft_d = 1'b1; end
            AO_SHA: begin bool_d = 2'b11; shft_d = 1'b1; end
            AO_AND: bool_d = 2'b00;
            AO_OR:  bool_d = 2'b01;
            AO_XOR: bool_d = 2'b10;
            AO_NOR: bool_d = 2'b11;
            default: ;
        endcase
        fn_d                   = '0;
        fn_d[B_SUB]            = sub_d;
        fn_d[B_BOOL+1:B_BOOL]  = bool_d;
        fn_d[B_SHFT]           = shft_d;
        fn_d[B_MATH]           = math_d;
    end

    assign alu_fn = fn_d;

endmodule

// File: rtl/ctl_sel_gen.sv
module ctl_sel_gen
    import ctl_pkg::*;
(
    input  kind_e  kind,
    input  logic   sext,
    input  logic   zero,
    output ctl_t   sel
);

    ctl_t sel_d;
    logic take_d;

    always_comb begin
        take_d = (kind == K_BR_EQ) ? zero : !zero;
        sel_d  = '0;
        unique case (kind)
            K_ALU_R: begin
                sel_d.wa_sel = WA_RD;
                sel_d.wd_sel = WD_ALU;
                sel_d.rf_we  = 1'b1;
            end
            K_SHIFT_C: begin
                sel_d.wa_sel = WA_RD;
                sel_d.wd_sel = WD_ALU;
                sel_d.a_sel  = AS_SHAMT;
                sel_d.rf_we  = 1'b1;
            end
            K_SHIFT_V: begin
                sel_d.wa_sel = WA_RD;
                sel_d.wd_sel = WD_ALU;
                sel_d.a_sel  = AS_REG;
                sel_d.rf_we  = 1'b1;
            end
            K_JREG: sel_d.pc_sel = PC_REG;
            K_JREG_L: begin
                sel_d.pc_sel = PC_REG;
                sel_d.wa_sel = WA_RD;
                sel_d.wd_sel = WD_LINK;
                sel_d.rf_we  = 1'b1;
            end
            K_ALU_I: begin
                sel_d.wa_sel   = WA_RT;
                sel_d.wd_sel   = WD_ALU;
                sel_d.b_sel    = 1'b1;
                sel_d.sign_ext = sext;
                sel_d.rf_we    = 1'b1;
            end
            K_UPPER: begin
                sel_d.wa_sel = WA_RT;
                sel_d.wd_sel = WD_ALU;
                sel_d.a_sel  = AS_K16;
                sel_d.b_sel  = 1'b1;
                sel_d.rf_we  = 1'b1;
            end
            K_LOAD: begin
                sel_d.wa_sel   = WA_RT;
                sel_d.wd_sel   = WD_MEM;
                sel_d.b_sel    = 1'b1;
                sel_d.sign_ext = sext;
                sel_d.rf_we    = 1'b1;
            end
            K_STORE: begin
                sel_d.b_sel    = 1'b1;
                sel_d.sign_ext = sext;
                sel_d.mem_we   = 1'b1;
            end
            K_BR_EQ, K_BR_NE: begin
                sel_d.sign_ext = sext;
                sel_d.pc_sel   = take_d ? PC_BR : PC_SEQ;
            end
            K_JMP: sel_d.pc_sel = PC_JMP;
            K_JMP_L: begin
                sel_d.pc_sel = PC_JMP;
                sel_d.wa_sel = WA_LINK;
                sel_d.wd_sel = WD_LINK;
                sel_d.rf_we  = 1'b1;
            end
            default: sel_d.bad_op = 1'b1;
        endcase
    end

    assign sel = sel_d;

endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
    import ctl_pkg::*;
(
    input  logic [OP_W-1:0]    op,
    input  logic [FN_W-1:0]    funct,
    input  logic               zero,
    output logic [SEL_W-1:0]   pc_sel,
    output logic [SEL_W-1:0]   wa_sel,
    output logic [SEL_W-1:0]   wd_sel,
    output logic [SEL_W-1:0]   a_sel,
    output logic               b_sel,
    output logic               sign_ext,
    output logic [ALUFN_W-1:0] alu_fn,
    output logic               rf_we,
    output logic               mem_we,
    output logic               bad_op
);

    kind_e              kind;
    aluop_e             aluop;
    logic               sext;
    logic [ALUFN_W-1:0] fn;
    ctl_t               sel;
    ctl_t               ctl_d;

    ctl_classify u_class (
        .op    (op),
        .funct (funct),
        .kind  (kind),
        .aluop (aluop),
        .sext  (sext)
    );

    ctl_alu_enc u_alu (
        .aluop  (aluop),
        .alu_fn (fn)
    );

    ctl_sel_gen u_sel (
        .kind (kind),
        .sext (sext),
        .zero (zero),
        .sel  (sel)
    );

    always_comb begin
        ctl_d        = sel;
        ctl_d.alu_fn = fn;
    end

    assign pc_sel   = ctl_d.pc_sel;
    assign wa_sel   = ctl_d.wa_sel;
    assign wd_sel   = ctl_d.wd_sel;
    assign a_sel    = ctl_d.a_sel;
    assign b_sel    = ctl_d.b_sel;
    assign sign_ext = ctl_d.sign_ext;
    assign alu_fn   = ctl_d.alu_fn;
    assign rf_we    = ctl_d.rf_we;
    assign mem_we   = ctl_d.mem_we;
    assign bad_op   = ctl_d.bad_op;

endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk
    import ctl_pkg::*;
(
    input logic [OP_W-1:0]    op,
    input logic [FN_W-1:0]    funct,
    input logic               zero,
    input logic [SEL_W-1:0]   pc_sel,
    input logic [SEL_W-1:0]   wa_sel,
    input logic [SEL_W-1:0]   wd_sel,
    input logic [SEL_W-1:0]   a_sel,
    input logic               b_sel,
    input logic               sign_ext,
    input logic [ALUFN_W-1:0] alu_fn,
    input logic               rf_we,
    input logic               mem_we,
    input logic               bad_op
);

    always_comb begin
        assert_store_only_R10: assert (!mem_we || (op == OPC_STORE && !rf_we))
            else $error("memory write outside store");
        assert_bad_quiet_R11: assert (!bad_op || (!rf_we && !mem_we && pc_sel == PC_SEQ))
            else $error("unsupported code changes state");
        assert_branch_nowrite_R7: assert (!(op == OPC_BR_EQ || op == OPC_BR_NE) || (!rf_we && alu_fn == 5'b10001))
            else $error("branch writes register or wrong ALU code");
        assert_jump_target_R8: assert (pc_sel != PC_JMP || op[OP_W-1:1] == 5'b00001)
            else $error("jump target chosen by non-jump");
        assert_reg_target_R9: assert (pc_sel != PC_REG || (op == OPC_REG && funct[FN_W-1:1] == 5'b00100))
            else $error("register target chosen by non-jump-register");
        assert_k16_upper_R5: assert (a_sel != AS_K16 || (op == OPC_UPPER && b_sel))
            else $error("constant 16 used outside load-upper");
        assert_link_reg_R8: assert (wa_sel != WA_LINK || (op == OPC_JMP_LINK && wd_sel == WD_LINK))
            else $error("register 31 written by wrong instruction");
    end

endmodule

bind ctl_decoder ctl_decoder_chk u_chk (.*);

// File: tb/tb_ctl_decoder.sv
module tb_ctl_decoder;
    import ctl_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [5:0] op, funct;
    logic       zero;
    logic [1:0] pc_sel, wa_sel, wd_sel, a_sel;
    logic       b_sel, sign_ext, rf_we, mem_we, bad_op;
    logic [4:0] alu_fn;

    int checks   = 0;
    int failures = 0;

    ctl_decoder dut (
        .op(op), .funct(funct), .zero(zero),
        .pc_sel(pc_sel), .wa_sel(wa_sel), .wd_sel(wd_sel), .a_sel(a_sel),
        .b_sel(b_sel), .sign_ext(sign_ext), .alu_fn(alu_fn),
        .rf_we(rf_we), .mem_we(mem_we), .bad_op(bad_op)
    );

    // vector: req(4) op(6) funct(6) zero(1) | pc wa wd a (2 each) b s alu(5) rf mw bad
    localparam int NV = 40;
    localparam logic [34:0] VEC [NV] = '{
        35'b0001_000000_100000_0_00_00_01_00_0_0_00001_1_0_0, // R1 add
        35'b0001_000000_100001_0_00_00_01_00_0_0_00001_1_0_0, // R1 addu
        35'b0001_000000_100010_0_00_00_01_00_0_0_10001_1_0_0, // R1 sub
        35'b0001_000000_100011_0_00_00_01_00_0_0_10001_1_0_0, // R1 subu
        35'b0001_000000_100100_0_00_00_01_00_0_0_00000_1_0_0, // R1 and
        35'b0001_000000_100101_0_00_00_01_00_0_0_00100_1_0_0, // R1 or
        35'b0001_000000_100110_0_00_00_01_00_0_0_01000_1_0_0, // R1 xor
        35'b0001_000000_100111_0_00_00_01_00_0_0_01100_1_0_0, // R1 nor
        35'b0010_000000_000000_0_00_00_01_01_0_0_00010_1_0_0, // R2 shl const
        35'b0010_000000_000010_0_00_00_01_01_0_0_01010_1_0_0, // R2 shr const
        35'b0010_000000_000011_0_00_00_01_01_0_0_01110_1_0_0, // R2 sha const
        35'b0010_000000_000100_0_00_00_01_00_0_0_00010_1_0_0, // R2 shl var
        35'b0010_000000_000110_0_00_00_01_00_0_0_01010_1_0_0, // R2 shr var
        35'b0010_000000_000111_0_00_00_01_00_0_0_01110_1_0_0, // R2 sha var
        35'b0011_000000_101010_0_00_00_01_00_0_0_10011_1_0_0, // R3 slt
        35'b0011_000000_101011_0_00_00_01_00_0_0_10111_1_0_0, // R3 sltu
        35'b0011_001010_000000_0_00_01_01_00_1_1_10011_1_0_0, // R3 slti
        35'b0011_001011_000000_0_00_01_01_00_1_1_10111_1_0_0, // R3 sltiu
        35'b0100_001000_000000_0_00_01_01_00_1_1_00001_1_0_0, // R4 addi
        35'b0100_001001_000000_0_00_01_01_00_1_1_00001_1_0_0, // R4 addiu
        35'b0100_001100_000000_0_00_01_01_00_1_0_00000_1_0_0, // R4 andi
        35'b0100_001101_000000_0_00_01_01_00_1_0_00100_1_0_0, // R4 ori
        35'b0100_001110_000000_0_00_01_01_00_1_0_01000_1_0_0, // R4 xori
        35'b0101_001111_000000_0_00_01_01_10_1_0_00010_1_0_0, // R5 upper
        35'b0110_100011_000000_0_00_01_10_00_1_1_00001_1_0_0, // R6 load
        35'b0110_101011_000000_0_00_00_00_00_1_1_00001_0_1_0, // R6 store
        35'b0111_000100_000000_1_01_00_00_00_0_1_10001_0_0_0, // R7 beq taken
        35'b0111_000100_000000_0_00_00_00_00_0_1_10001_0_0_0, // R7 beq not taken
        35'b0111_000101_000000_0_01_00_00_00_0_1_10001_0_0_0, // R7 bne taken
        35'b0111_000101_000000_1_00_00_00_00_0_1_10001_0_0_0, // R7 bne not taken
        35'b1000_000010_000000_0_10_00_00_00_0_0_00000_0_0_0, // R8 j
        35'b1000_000011_000000_0_10_10_00_00_0_0_00000_1_0_0, // R8 jal
        35'b1001_000000_001000_0_11_00_00_00_0_0_00000_0_0_0, // R9 jr
        35'b1001_000000_001001_0_11_00_00_00_0_0_00000_1_0_0, // R9 jalr
        35'b1011_111111_000000_0_00_00_00_00_0_0_00000_0_0_1, // R11 bad op
        35'b1011_100000_000000_0_00_00_00_00_0_0_00000_0_0_1, // R11 byte load unsupported
        35'b1011_000000_001010_0_00_00_00_00_0_0_00000_0_0_1, // R11 bad funct
        35'b1011_000000_011000_1_00_00_00_00_0_0_00000_0_0_1, // R11 bad funct, zero set
        35'b1100_001000_100010_1_00_01_01_00_1_1_00001_1_0_0, // R12 funct/zero ignored on addi
        35'b1100_000000_100000_1_00_00_01_00_0_0_00001_1_0_0  // R12 zero ignored on add
    };

    function automatic logic [17:0] outs();
        return {pc_sel, wa_sel, wd_sel, a_sel, b_sel, sign_ext, alu_fn, rf_we, mem_we, bad_op};
    endfunction

    task automatic apply(input logic [5:0] o, input logic [5:0] f, input logic z);
        @(posedge clk);
        op = o; funct = f; zero = z;
        @(negedge clk);
    endtask

    task automatic check(input int req, input logic [17:0] got, input logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL R%0d got=%b exp=%b (op=%b funct=%b zero=%b)", req, got, exp, op, funct, zero);
        end
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired got=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        op = '0; funct = '0; zero = 1'b0;
        // initial state: op 0 / funct 0 is a constant left shift (R2)
        @(negedge clk);
        check(2, outs(), 18'b00_00_01_01_0_0_00010_1_0_0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][30:25], VEC[i][24:19], VEC[i][18]);
            check(int'(VEC[i][34:31]), outs(), VEC[i][17:0]);
        end

        // R10: mem_we only for store; sweep all opcodes
        for (int o = 0; o < 64; o++) begin
            apply(6'(o), 6'b100000, 1'b0);
            check(10, {17'b0, mem_we}, {17'b0, (o == 43)});
        end

        // R12: zero toggles pc_sel of branch only; other outputs held
        apply(6'b000100, 6'b000000, 1'b0);
        begin
            logic [17:0] a0;
            a0 = outs();
            apply(6'b000100, 6'b000000, 1'b1);
            check(12, {2'b00, outs()[15:0]}, {2'b00, a0[15:0]});
            check(7, {16'b0, pc_sel}, {16'b0, 2'd1});
        end

        // R12: funct ignored for non-register opcodes (store with every funct)
        for (int f = 0; f < 64; f += 7) begin
            apply(6'b101011, 6'(f), f[0]);
            check(12, outs(), 18'b00_00_00_00_1_1_00001_0_1_0);
        end

        // R11: every unlisted funct under register opcode is flagged
        for (int f = 0; f < 64; f++) begin
            logic ok;
            ok = (f == 0) || (f == 2) || (f == 3) || (f == 4) || (f == 6) || (f == 7) ||
                 (f == 8) || (f == 9) || (f >= 32 && f <= 39) || (f == 42) || (f == 43);
            apply(6'b000000, 6'(f), 1'b0);
            if (ok) check(11, {17'b0, bad_op}, 18'b0);
            else    check(11, {bad_op, rf_we, mem_we, pc_sel, 13'b0}, {1'b1, 1'b0, 1'b0, 2'b00, 13'b0});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule